// File: doc/BRIEF.md
# Converter Result Register Bank with Grouped Shadow Publishing

This block stores the 12-bit results of a successive-approximation converter in registers that software can read. Each finished conversion arrives as a one-cycle strobe. The strobe carries a target flag, a slot index and the result value. A strobe aimed at a primary slot writes that slot's result register straight away. A strobe aimed at a shadowed slot is handled differently. When shadow mode is on, the result goes first into a hidden buffer. Software sees it only after a publish pulse for that slot's group.

The five shadowed slots fall into two groups. Group A holds slots 0 to 2 and group B holds slots 3 and 4. Each group has its own publish pulse, and each pulse copies all slots of its group in one edge. This keeps related samples consistent with each other when software reads them. A single read port gives either a 16-bit left-justified word or the upper 8 bits of the result. The read address is registered, so data appears one cycle after the address is presented.

Top module: `adc_result_bank`

## Requirements
- R1: A strobe with `done_ext_i`=0 writes `done_res_i` into primary register `done_slot_i` (0..15) at the next edge, whatever the mode.
- R2: In word view (`rd_byte_i`=0) the 12-bit result occupies bits 15:4 and bits 3:0 read as zero.
- R3: In byte view (`rd_byte_i`=1), bits 7:0 return result bits 11:4 and bits 15:8 read as zero.
- R4: With `ext_mode_i`=1, a strobe with `done_ext_i`=1 and slot 0..4 writes only the hidden buffer of that slot. The readable shadowed register is unchanged until its group is published.
- R5: `grp_a_load_i` copies hidden buffers 0, 1 and 2 into readable shadowed registers 0, 1 and 2 at the same edge.
- R6: `grp_b_load_i` copies hidden buffers 3 and 4 into readable shadowed registers 3 and 4 at the same edge.
- R7: When a publish pulse and a buffer write to the same group share an edge, the published value is the buffer content from before that edge. The new result stays in the buffer for the next publish.
- R8: When both publish pulses share an edge, each group copies its own buffers, independently of the other.
- R9: After reset every register reads zero. Read address map: 0..15 are primary slots, 16..20 are shadowed slots 0..4, and all other addresses read zero. `rd_data_o` reflects the address and view sampled at the previous edge.
- R10: Strobes with `done_ext_i`=1 have no effect on any register when `ext_mode_i`=0 or when the slot is 5 or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_mode_i | input | 1 | Shadow (extension buffer) mode enable |
| done_i | input | 1 | Conversion-done strobe |
| done_ext_i | input | 1 | Strobe targets a shadowed slot (1) or a primary slot (0) |
| done_slot_i | input | 4 | Target slot index |
| done_res_i | input | 12 | Conversion result |
| grp_a_load_i | input | 1 | Publish pulse for shadowed slots 0..2 |
| grp_b_load_i | input | 1 | Publish pulse for shadowed slots 3..4 |
| rd_addr_i | input | 5 | Read address |
| rd_byte_i | input | 1 | Byte view select |
| rd_data_o | output | 16 | Read data, one cycle after address |

## Verification
The bench aims at edges where a publish pulse and a buffer write to the same group coincide. A design that wrote through to the readable register, or that ordered the copy after the write, would publish the new result one pulse early. Both pulses are fired together, and some pulses are given to only one group, so a design that cross-wired the groups or shared one enable would update the wrong slots. Shadowed strobes are sent with the mode off and to slot indices 5 and up. Later publishes then show whether any of them leaked into a buffer. Word and byte views are read at every address, including the unmapped ones. This catches a mis-justified result or a stale read address.

// File: rtl/adc_res_pkg.sv
package adc_res_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic {
    VIEW_WORD = 1'b0,
    VIEW_BYTE = 1'b1
  } view_e;
endpackage

// File: rtl/adc_norm_bank.sv
module adc_norm_bank #(
  parameter int RES_W    = 12,
  parameter int NUM_NORM = 16,
  parameter int SLOT_W   = 4
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_i,
  input  logic [SLOT_W-1:0]                slot_i,
  input  logic [RES_W-1:0]                 res_i,
  output logic [NUM_NORM-1:0][RES_W-1:0]   reg_o
);
  for (genvar g = 0; g < NUM_NORM; g++) begin : g_slot
    logic hit;
    assign hit = wr_i && (slot_i == SLOT_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  reg_o[g] <= '0;
      else if (hit) reg_o[g] <= res_i;
    end
  end
endmodule

// File: rtl/adc_ext_bank.sv
module adc_ext_bank #(
  parameter int RES_W   = 12,
  parameter int NUM_EXT = 5,
  parameter int GRP_A_N = 3,
  parameter int SLOT_W  = 4
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_i,
  input  logic [SLOT_W-1:0]               slot_i,
  input  logic [RES_W-1:0]                res_i,
  input  logic                            grp_a_load_i,
  input  logic                            grp_b_load_i,
  output logic [NUM_EXT-1:0][RES_W-1:0]   buf_o,
  output logic [NUM_EXT-1:0][RES_W-1:0]   pub_o
);
  for (genvar g = 0; g < NUM_EXT; g++) begin : g_slot
    logic hit, load;
    assign hit = wr_i && (slot_i == SLOT_W'(g));
    // group membership picked by slot position
    if (g < GRP_A_N) begin : g_grp_a
      assign load = grp_a_load_i;
    end else begin : g_grp_b
      assign load = grp_b_load_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  buf_o[g] <= '0;
      else if (hit) buf_o[g] <= res_i;
    end

    // nonblocking copy takes the pre-edge buffer value
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   pub_o[g] <= '0;
      else if (load) pub_o[g] <= buf_o[g];
    end
  end
endmodule

// File: rtl/adc_rd_port.sv
module adc_rd_port
  import adc_res_pkg::*;
#(
  parameter int RES_W    = 12,
  parameter int REG_W    = 16,
  parameter int NUM_NORM = 16,
  parameter int NUM_EXT  = 5,
  parameter int ADDR_W   = 5
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [ADDR_W-1:0]               rd_addr_i,
  input  logic                            rd_byte_i,
  input  logic [NUM_NORM-1:0][RES_W-1:0]  norm_i,
  input  logic [NUM_EXT-1:0][RES_W-1:0]   ext_i,
  output logic [REG_W-1:0]                rd_data_o
);
  localparam int PAD_W = REG_W - RES_W;

  logic [ADDR_W-1:0] addr_q;
  view_e             view_q;
  logic [RES_W-1:0]  sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      view_q <= VIEW_WORD;
    end else begin
      addr_q <= rd_addr_i;
      view_q <= view_e'(rd_byte_i);
    end
  end

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_NORM; i++)
      if (addr_q == ADDR_W'(i)) sel = norm_i[i];
    for (int i = 0; i < NUM_EXT; i++)
      if (addr_q == ADDR_W'(NUM_NORM + i)) sel = ext_i[i];
  end

  always_comb begin
    if (view_q == VIEW_BYTE)
      rd_data_o = {{(REG_W-BYTE_W){1'b0}}, sel[RES_W-1 -: BYTE_W]};
    else
      rd_data_o = {sel, {PAD_W{1'b0}}};
  end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int RES_W    = 12,
  parameter int REG_W    = 16,
  parameter int NUM_NORM = 16,
  parameter int NUM_EXT  = 5,
  parameter int GRP_A_N  = 3,
  localparam int SLOT_W  = $clog2(NUM_NORM),
  localparam int ADDR_W  = $clog2(NUM_NORM + NUM_EXT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_mode_i,
  input  logic              done_i,
  input  logic              done_ext_i,
  input  logic [SLOT_W-1:0] done_slot_i,
  input  logic [RES_W-1:0]  done_res_i,
  input  logic              grp_a_load_i,
  input  logic              grp_b_load_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              rd_byte_i,
  output logic [REG_W-1:0]  rd_data_o
);
  logic [NUM_NORM-1:0][RES_W-1:0] norm_q;
  logic [NUM_EXT-1:0][RES_W-1:0]  ext_buf_q;
  logic [NUM_EXT-1:0][RES_W-1:0]  ext_pub_q;
  logic norm_wr, ext_wr;

  assign norm_wr = done_i && !done_ext_i;
  assign ext_wr  = done_i && done_ext_i && ext_mode_i;

  adc_norm_bank #(
    .RES_W(RES_W), .NUM_NORM(NUM_NORM), .SLOT_W(SLOT_W)
  ) u_norm (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(norm_wr),
    .slot_i(done_slot_i), .res_i(done_res_i), .reg_o(norm_q)
  );

  adc_ext_bank #(
    .RES_W(RES_W), .NUM_EXT(NUM_EXT), .GRP_A_N(GRP_A_N), .SLOT_W(SLOT_W)
  ) u_ext (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(ext_wr),
    .slot_i(done_slot_i), .res_i(done_res_i),
    .grp_a_load_i(grp_a_load_i), .grp_b_load_i(grp_b_load_i),
    .buf_o(ext_buf_q), .pub_o(ext_pub_q)
  );

  adc_rd_port #(
    .RES_W(RES_W), .REG_W(REG_W), .NUM_NORM(NUM_NORM),
    .NUM_EXT(NUM_EXT), .ADDR_W(ADDR_W)
  ) u_rd (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_addr_i(rd_addr_i),
    .rd_byte_i(rd_byte_i), .norm_i(norm_q), .ext_i(ext_pub_q),
    .rd_data_o(rd_data_o)
  );
endmodule

// File: rtl/adc_result_bank_chk.sv
module adc_result_bank_chk #(
  parameter int RES_W    = 12,
  parameter int REG_W    = 16,
  parameter int NUM_NORM = 16,
  parameter int NUM_EXT  = 5,
  parameter int GRP_A_N  = 3,
  parameter int SLOT_W   = 4
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           ext_mode_i,
  input logic                           done_i,
  input logic                           done_ext_i,
  input logic [SLOT_W-1:0]              done_slot_i,
  input logic [RES_W-1:0]               done_res_i,
  input logic                           grp_a_load_i,
  input logic                           grp_b_load_i,
  input logic                           rd_byte_i,
  input logic [REG_W-1:0]               rd_data_o,
  input logic [NUM_NORM-1:0][RES_W-1:0] norm_q,
  input logic [NUM_EXT-1:0][RES_W-1:0]  ext_buf_q,
  input logic [NUM_EXT-1:0][RES_W-1:0]  ext_pub_q
);
  // R1
  norm_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !done_ext_i) |=> norm_q[$past(done_slot_i)] == $past(done_res_i));

  // R2
  word_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rd_byte_i) |-> rd_data_o[REG_W-RES_W-1:0] == '0);

  // R3
  byte_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_byte_i) |-> rd_data_o[REG_W-1:8] == '0);

  // R4
  pub_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!grp_a_load_i && !grp_b_load_i) |=> $stable(ext_pub_q));

  // R5
  grp_a_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_a_load_i |=> ext_pub_q[0] == $past(ext_buf_q[0]) &&
                     ext_pub_q[GRP_A_N-1] == $past(ext_buf_q[GRP_A_N-1]));

  // R6
  grp_b_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_b_load_i |=> ext_pub_q[GRP_A_N] == $past(ext_buf_q[GRP_A_N]) &&
                     ext_pub_q[NUM_EXT-1] == $past(ext_buf_q[NUM_EXT-1]));

  // R10
  mode_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_mode_i |=> $stable(ext_buf_q));
endmodule

bind adc_result_bank adc_result_bank_chk #(
  .RES_W(RES_W), .REG_W(REG_W), .NUM_NORM(NUM_NORM),
  .NUM_EXT(NUM_EXT), .GRP_A_N(GRP_A_N), .SLOT_W(SLOT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ext_mode_i(ext_mode_i),
  .done_i(done_i), .done_ext_i(done_ext_i), .done_slot_i(done_slot_i),
  .done_res_i(done_res_i), .grp_a_load_i(grp_a_load_i),
  .grp_b_load_i(grp_b_load_i), .rd_byte_i(rd_byte_i),
  .rd_data_o(rd_data_o), .norm_q(norm_q), .ext_buf_q(ext_buf_q),
  .ext_pub_q(ext_pub_q)
);

// File: tb/adc_result_bank_test.sv
module adc_result_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_mode = 1'b0, done = 1'b0, done_ext = 1'b0;
  logic [3:0]  slot = '0;
  logic [11:0] res = '0;
  logic        lda = 1'b0, ldb = 1'b0;
  logic [4:0]  addr = '0;
  logic        byte_v = 1'b0;
  logic [15:0] rd_data;

  int vectors = 0, fails = 0, cycles = 0;
  string cur_req = "R9";

  int norm_m[16];
  int buf_m[5];
  int pub_m[5];
  int addr_m = 0;
  bit byte_m = 0;

  always #2 clk = ~clk;

  adc_result_bank uut (
    .clk_i(clk), .rst_ni(rst_n), .ext_mode_i(ext_mode), .done_i(done),
    .done_ext_i(done_ext), .done_slot_i(slot), .done_res_i(res),
    .grp_a_load_i(lda), .grp_b_load_i(ldb), .rd_addr_i(addr),
    .rd_byte_i(byte_v), .rd_data_o(rd_data)
  );

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (norm_m[i]) norm_m[i] = 0;
      foreach (buf_m[i]) begin buf_m[i] = 0; pub_m[i] = 0; end
      addr_m = 0; byte_m = 0;
    end else begin
      if (lda) for (int i = 0; i < 3; i++) pub_m[i] = buf_m[i];
      if (ldb) for (int i = 3; i < 5; i++) pub_m[i] = buf_m[i];
      if (done && !done_ext) norm_m[slot] = res;
      if (done && done_ext && ext_mode && slot < 5) buf_m[slot] = res;
      addr_m = addr; byte_m = byte_v;
    end
  end

  function automatic logic [15:0] expect_rd();
    int v = 0;
    if (addr_m < 16) v = norm_m[addr_m];
    else if (addr_m < 21) v = pub_m[addr_m-16];
    if (byte_m) return {8'h00, 8'((v >> 4) & 8'hff)};
    return 16'((v & 12'hfff) << 4);
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      logic [15:0] e;
      e = expect_rd();
      vectors++;
      if (rd_data !== e) begin
        fails++;
        $display("FAIL %s addr=%0d byte=%0d actual=%h expected=%h",
                 cur_req, addr_m, byte_m, rd_data, e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<20000 cycles", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic cyc(input bit d, input bit de, input int s, input int r,
                     input bit a, input bit b, input int ad, input bit by);
    @(negedge clk);
    done = d; done_ext = de; slot = 4'(s); res = 12'(r);
    lda = a; ldb = b; addr = 5'(ad); byte_v = by;
  endtask

  task automatic rd(input int ad, input bit by);
    cyc(0, 0, 0, 0, 0, 0, ad, by);
    cyc(0, 0, 0, 0, 0, 0, ad, by);
  endtask

  task automatic sweep();
    for (int a = 0; a < 32; a++) begin rd(a, 0); rd(a, 1); end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R9";
    sweep();

    // R1 primary writes, R2 word view, R3 byte view
    cur_req = "R1";
    for (int i = 0; i < 16; i++) cyc(1, 0, i, 12'h0a5 + i * 12'h111, 0, 0, i, 0);
    cur_req = "R2"; for (int i = 0; i < 16; i++) rd(i, 0);
    cur_req = "R3"; for (int i = 0; i < 16; i++) rd(i, 1);

    // R10 mode off, shadow strobes ignored
    cur_req = "R10";
    for (int i = 0; i < 8; i++) cyc(1, 1, i, 12'hf00 + i, 0, 0, 16, 0);
    cyc(0, 0, 0, 0, 1, 1, 16, 0);
    for (int i = 16; i < 21; i++) rd(i, 0);

    // R4 buffered writes invisible until publish
    ext_mode = 1'b1;
    cur_req = "R4";
    for (int i = 0; i < 5; i++) cyc(1, 1, i, 12'h3c1 + i * 12'h205, 0, 0, 16, 0);
    for (int i = 16; i < 21; i++) rd(i, 0);

    // R5 group A publish only
    cur_req = "R5";
    cyc(0, 0, 0, 0, 1, 0, 16, 0);
    for (int i = 16; i < 21; i++) rd(i, 0);

    // R6 group B publish only
    cur_req = "R6";
    cyc(0, 0, 0, 0, 0, 1, 19, 0);
    for (int i = 16; i < 21; i++) rd(i, 1);

    // R7 publish coinciding with buffer write
    cur_req = "R7";
    cyc(1, 1, 1, 12'h777, 1, 0, 17, 0);
    rd(17, 0);
    cyc(1, 1, 4, 12'h888, 0, 1, 20, 0);
    rd(20, 0);
    cyc(0, 0, 0, 0, 1, 1, 17, 0);
    rd(17, 0); rd(20, 0);

    // R8 both groups together
    cur_req = "R8";
    cyc(1, 1, 0, 12'h123, 0, 0, 16, 0);
    cyc(1, 1, 3, 12'h456, 0, 0, 16, 0);
    cyc(0, 0, 0, 0, 1, 1, 16, 0);
    for (int i = 16; i < 21; i++) rd(i, 0);

    // R1 primary write while shadow mode on
    cur_req = "R1";
    cyc(1, 0, 2, 12'hbee, 0, 0, 2, 0);
    rd(2, 0);

    // mixed random traffic
    cur_req = "R7";
    for (int n = 0; n < 2000; n++) begin
      ext_mode = ($urandom_range(0, 3) != 0);
      cyc($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 15),
          $urandom_range(0, 4095), $urandom_range(0, 3) == 0,
          $urandom_range(0, 3) == 0, $urandom_range(0, 31), $urandom_range(0, 1));
    end
    cur_req = "R9";
    sweep();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule